// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the read and write strobes of programmed-I/O transfers on an IDE bus. Each transfer has two phases. In the active phase the strobe is asserted. In the recovery phase it is negated. Both phase lengths are counted in local-bus clocks. A requester raises a one-clock request together with a direction bit and an 8-bit timing byte. The block drives the matching active-low strobe for the active phase, waits out the recovery phase, and pulses `done` on the last clock of the transfer.

The timing byte stores each phase length as an offset taken away from a base. The base depends on the encoding in use.
- In the dual-channel encoding, the whole low nibble gives the active length and the high nibble gives the recovery length.
- In the single-channel encoding, only the low three bits give the active length. Bit 3 is a fixed marker. A bus-speed strap then picks one of two base pairs, one for a slower local bus and one for a faster one.

The encoding strap and the bus-speed strap are read at the start of each transfer, together with the byte and the direction. One request may wait while a transfer is in progress.

Top module: `ide_pio_timer`

## Requirements
- R1: While reset is asserted, and at the first clock after it, both strobes are high (negated) and `done` is low.
- R2: With `dual_fmt`=1, the active phase lasts 17 minus `timing[3:0]` clocks, which gives 2 to 17 clocks.
- R3: With `dual_fmt`=1, the recovery phase lasts 15 minus `timing[7:4]` clocks. The result never goes below 2, so codes 14 and 15 both give 2 clocks.
- R4: With `dual_fmt`=0 and `slow_bus`=1, the active phase lasts 9 minus `timing[2:0]` clocks and the recovery phase lasts 15 minus `timing[7:4]` clocks. `timing[3]` has no effect on either phase.
- R5: With `dual_fmt`=0 and `slow_bus`=0, the active phase lasts 8 minus `timing[2:0]` clocks and the recovery phase lasts 18 minus `timing[7:4]` clocks.
- R6: A recovery length of zero skips the recovery phase. A waiting request then asserts its strobe on the clock right after the last active clock.
- R7: A request that arrives during a transfer waits. Its strobe asserts on the clock right after the clock in which `done` pulses.
- R8: The timing byte, the direction and both straps are captured at the start of a transfer. Changing them later does not alter that transfer.
- R9: During the active phase exactly one strobe is low: `iow_n` when `wr`=1 was captured, `ior_n` when `wr`=0 was captured.
- R10: `done` is high for one clock per transfer. That clock is the last recovery clock, or the last active clock when the recovery length is zero.
- R11: A request sampled while the block is idle asserts its strobe on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-clock transfer request |
| wr | input | 1 | Direction: 1 selects a write, 0 selects a read |
| timing | input | 8 | Timing byte: recovery code in `[7:4]`, active code in the low bits |
| dual_fmt | input | 1 | Encoding strap: 1 selects dual-channel, 0 selects single-channel |
| slow_bus | input | 1 | Bus-speed strap for the single-channel encoding: 1 selects the slower bus |
| ior_n | output | 1 | Read strobe, active low |
| iow_n | output | 1 | Write strobe, active low |
| done | output | 1 | High on the final clock of a transfer |

## Verification
The assertions take three things for granted about the inputs:
- a requester never issues a second request while one is already waiting;
- the straps and the timing byte of a waiting request are held steady until its strobe appears;
- every legal code produces a phase of at least one clock.

The stimulus respects these by issuing at most one request during any transfer. It keeps the inputs fixed until the waiting transfer's strobe is seen. It changes the byte and the direction only after a strobe has asserted, which is how the capture rule is exercised.

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       wr,
  input  logic [7:0] timing,
  input  logic       dual_fmt,
  input  logic       slow_bus,
  output logic       ior_n,
  output logic       iow_n,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REC} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] rec_len;
  logic [CW-1:0] act_ld;
  logic [CW-1:0] rec_ld;
  logic          dir;
  logic          pend;
  logic          idle;
  logic          want;
  logic          act_last;
  logic          rec_last;
  logic          cyc_end;
  logic          start;

  always_comb begin
    if (dual_fmt) begin
      act_ld = CW'(17) - CW'(timing[3:0]);
      rec_ld = (timing[7:4] > 4'd13) ? CW'(2) : CW'(15) - CW'(timing[7:4]);
    end else if (slow_bus) begin
      act_ld = CW'(9) - CW'(timing[2:0]);
      rec_ld = CW'(15) - CW'(timing[7:4]);
    end else begin
      act_ld = CW'(8) - CW'(timing[2:0]);
      rec_ld = CW'(18) - CW'(timing[7:4]);
    end
  end

  assign idle     = (state == S_IDLE);
  assign want     = req | pend;
  assign act_last = (state == S_ACT) && (cnt == CW'(1));
  assign rec_last = (state == S_REC) && (cnt == CW'(1));
  assign cyc_end  = (act_last && rec_len == '0) || rec_last;
  assign start    = want && (idle || cyc_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rec_len <= '0;
      dir     <= 1'b0;
    end else if (start) begin
      state   <= S_ACT;
      cnt     <= act_ld;
      rec_len <= rec_ld;
      dir     <= wr;
    end else if (act_last) begin
      if (rec_len == '0) begin
        state <= S_IDLE;
      end else begin
        state <= S_REC;
        cnt   <= rec_len;
      end
    end else if (rec_last) begin
      state <= S_IDLE;
    end else if (!idle) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (!idle && !cyc_end) pend <= pend | req;
    else                       pend <= 1'b0;
  end

  assign ior_n = !((state == S_ACT) && !dir);
  assign iow_n = !((state == S_ACT) && dir);
  assign done  = cyc_end;

endmodule

module ide_pio_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ior_n,
  input logic iow_n,
  input logic done,
  input logic idle,
  input logic pend
);

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ior_n && !iow_n));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req) |=> (!ior_n || !iow_n));

  a_r7_pending_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (req || pend)) |=> (!ior_n || !iow_n));

  a_r8_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n && !done) |=> iow_n);

  a_r8_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!iow_n && !done) |=> ior_n);

endmodule

bind ide_pio_timer ide_pio_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ior_n(ior_n), .iow_n(iow_n),
  .done(done), .idle(idle), .pend(pend)
);

// File: tb/sim_ide_pio_timer.sv
module sim_ide_pio_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] timing = 8'h00;
  logic       dual_fmt = 1'b1;
  logic       slow_bus = 1'b1;
  logic       ior_n, iow_n, done;

  int checks = 0;
  int errors = 0;

  int    qa[$];
  int    qr[$];
  bit    qd[$];
  string qt[$];

  always #5 clk = ~clk;

  ide_pio_timer u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .timing(timing),
    .dual_fmt(dual_fmt), .slow_bus(slow_bus),
    .ior_n(ior_n), .iow_n(iow_n), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void model(input bit dl, input bit sl, input logic [7:0] t,
                                output int a, output int r);
    if (dl) begin
      a = 17 - int'(t[3:0]);
      r = 15 - int'(t[7:4]);
      if (r < 2) r = 2;
    end else if (sl) begin
      a = 9 - int'(t[2:0]);
      r = 15 - int'(t[7:4]);
    end else begin
      a = 8 - int'(t[2:0]);
      r = 18 - int'(t[7:4]);
    end
  endfunction

  task automatic issue(input string tag, input bit now);
    int a, r;
    @(negedge clk);
    req = 1'b1;
    model(dual_fmt, slow_bus, timing, a, r);
    qa.push_back(a);
    qr.push_back(r);
    qd.push_back(wr);
    qt.push_back(tag);
    @(negedge clk);
    req = 1'b0;
    if (now)
      check(wr ? (!iow_n && ior_n) : (!ior_n && iow_n), {tag, " R11 start next clock"},
            {ior_n, iow_n}, wr ? 2 : 1);
  endtask

  task automatic drain();
    while (qa.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic one(input string tag, input bit dl, input bit sl, input logic [7:0] t, input bit w);
    dual_fmt = dl; slow_bus = sl; timing = t; wr = w;
    issue(tag, 1'b1);
    drain();
  endtask

  bit seen = 1'b0;
  bit mdir = 1'b0;
  int act_n = 0;
  int rec_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ior_n || !iow_n) begin
        if (!seen) begin
          seen = 1'b1;
          act_n = 0;
          rec_n = 0;
          mdir = !iow_n;
        end
        act_n++;
      end else if (seen) begin
        rec_n++;
      end
      if (done) begin
        if (qa.size() == 0) begin
          check(1'b0, "R10 done with nothing expected", 1, 0);
        end else begin
          int a, r;
          bit d;
          string tg;
          a = qa.pop_front();
          r = qr.pop_front();
          d = qd.pop_front();
          tg = qt.pop_front();
          check(seen, {tg, " R10 done without strobe"}, 0, 1);
          check(mdir == d, {tg, " R9 direction"}, mdir, d);
          check(act_n == a, {tg, " active length"}, act_n, a);
          check(rec_n == r, {tg, " recovery length"}, rec_n, r);
        end
        seen = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ior_n && iow_n && !done, "R1 outputs in reset", {ior_n, iow_n, done}, 6);
    rst_n = 1'b1;
    @(negedge clk);
    check(ior_n && iow_n && !done, "R1 outputs after reset", {ior_n, iow_n, done}, 6);

    one("R2 R3 dual 00", 1, 1, 8'h00, 1'b0);
    one("R2 R3 dual DF", 1, 0, 8'hDF, 1'b1);
    one("R3 dual clamp F5", 1, 1, 8'hF5, 1'b0);
    one("R3 dual clamp E0", 1, 1, 8'hE0, 1'b1);
    one("R4 slow 08", 0, 1, 8'h08, 1'b0);
    one("R4 slow 37", 0, 1, 8'h37, 1'b1);
    one("R4 slow 3F bit3", 0, 1, 8'h3F, 1'b1);
    one("R5 fast 08", 0, 0, 8'h08, 1'b0);
    one("R5 fast FF", 0, 0, 8'hFF, 1'b1);
    one("R5 fast 7A", 0, 0, 8'h7A, 1'b0);

    // R6: zero recovery, second request waits then starts at once
    dual_fmt = 0; slow_bus = 1; timing = 8'hFA; wr = 1'b0;
    issue("R6 first", 1'b1);
    issue("R6 second", 1'b0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!ior_n, "R6 strobe right after done", ior_n, 0);
    drain();

    // R7: request during a transfer, with a new direction
    dual_fmt = 1; timing = 8'h33; wr = 1'b0;
    issue("R7 first", 1'b1);
    wr = 1'b1;
    issue("R7 second", 1'b0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!iow_n, "R7 pending strobe after done", iow_n, 0);
    drain();

    // R8: inputs changed after start do not alter the transfer
    dual_fmt = 1; slow_bus = 1; timing = 8'h2C; wr = 1'b1;
    issue("R8 captured", 1'b1);
    timing = 8'h00; wr = 1'b0; dual_fmt = 0; slow_bus = 0;
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule